// File: doc/BRIEF.md
# Pipelined Carry-Save Row Adder

This block adds eight WIDTH-bit rows, such as the partial products of a multiplier, and returns their sum modulo 2^WIDTH. The rows pass through a fixed tree of carry-save 3:2 compressor layers. The first layer reduces rows 0-2 and rows 3-5 in parallel. The second layer compresses the first group's sum and carry together with the second group's sum, and compresses rows 6 and 7 together with the second group's carry. Two further layers leave one sum row and one carry row. A single carry-propagate addition then combines those two rows. Every compressor's carry row moves up one bit position before the next layer uses it, and a carry pushed beyond the top bit is dropped.

Registers sit after the first layer, after the second layer and after the last two layers, so the tree holds three register stages. A fourth register sits after the final adder. Data enters and leaves over valid/ready streams. A row set is taken on a clock edge when `in_valid` and `in_ready` are both high. A result is handed over when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` drops. When `out_ready` is high, the block accepts a new row set on every cycle. Synchronous reset clears every stage.

Top module: `csa_tree_pipe`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals the sum of the eight rows of the corresponding accepted input, modulo 2^WIDTH. Row k occupies bits [k*WIDTH +: WIDTH] of `in_rows`.
- R2: Carries above bit WIDTH-1 are discarded. Eight rows of all ones give all ones except the three low bits, which read 000. Eight rows holding only the top bit give zero.
- R3: If the pipeline is empty and `out_ready` is high, a row set accepted at clock edge t produces `out_valid` after edge t+3 and not before.
- R4: With `out_ready` held high, a new row set is accepted on every cycle. Results come out in acceptance order, one per cycle, and none is lost or duplicated.
- R5: `in_ready` is low only while `out_valid` is high and `out_ready` is low. While the output is stalled, `out_valid` and `out_sum` hold. An empty pipeline stalled at the output takes exactly four row sets before `in_ready` falls.
- R6: Rows presented while `in_valid` is low are ignored and never produce an output.
- R7: Synchronous reset clears every stage. `out_valid` is low after reset, `in_ready` is high, and row sets in flight at reset never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input row set is present |
| in_ready | output | 1 | Block will take the row set on this edge |
| in_rows | input | 8*WIDTH | Eight rows, row k at bits [k*WIDTH +: WIDTH] |
| out_valid | output | 1 | `out_sum` holds a result |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_sum | output | WIDTH | Sum of the eight rows, modulo 2^WIDTH |

## Verification
The bench builds the block with the default WIDTH of 32, so the top bit and the carries dropped out of it are exercised at full width. Eight all-ones rows and eight top-bit rows reach the wrap cases. Alternating and single-bit patterns drive long carry chains through every compressor layer. At this width the four-deep pipeline can be filled to its limit under output stall and then drained.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;
  // Number of input rows; the compressor grouping below is fixed for eight.
  localparam int unsigned NUM_ROWS   = 8;
  // Rows held in each register stage of the tree.
  localparam int unsigned S1_ROWS    = 6;
  localparam int unsigned S2_ROWS    = 4;
  localparam int unsigned S3_ROWS    = 2;
  // Register stages inside the tree plus the one after the final adder.
  localparam int unsigned TREE_REGS  = 3;
  localparam int unsigned LATENCY    = TREE_REGS + 1;
endpackage

// File: rtl/csa_layer.sv
// One row of 3:2 compressor cells; the carry row leaves already aligned one bit up.
module csa_layer #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] s,
  output logic [WIDTH-1:0] cy
);
  localparam int unsigned TOP = WIDTH - 1;

  assign cy[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_sum
      assign s[i] = a[i] ^ b[i] ^ c[i];
    end
    // The majority of the top bit column would land above the row and is dropped.
    for (i = 0; i < TOP; i++) begin : g_carry
      assign cy[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end
  endgenerate
endmodule

// File: rtl/csa_pipe_stage.sv
// Register stage for a bundle of rows plus its valid bit, frozen when en is low.
module csa_pipe_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ROWS  = 1,
  localparam int unsigned BITS = WIDTH * ROWS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            vld_i,
  input  logic [BITS-1:0] dat_i,
  output logic            vld_o,
  output logic [BITS-1:0] dat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else if (en) begin
      vld_o <= vld_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/csa_final_add.sv
// Carry-propagate merge of the redundant sum and carry rows.
module csa_final_add #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum_row,
  input  logic [WIDTH-1:0] carry_row,
  output logic [WIDTH-1:0] total
);
  assign total = sum_row + carry_row;
endmodule

// File: rtl/csa_tree_pipe.sv
module csa_tree_pipe
  import csa_tree_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IN_BITS = NUM_ROWS * WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_BITS-1:0] in_rows,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WIDTH-1:0]   out_sum
);
  localparam int unsigned S1_BITS = S1_ROWS * WIDTH;
  localparam int unsigned S2_BITS = S2_ROWS * WIDTH;
  localparam int unsigned S3_BITS = S3_ROWS * WIDTH;

  // Global advance: every stage moves together unless the result is stalled.
  logic advance;
  assign advance  = ~out_valid | out_ready;
  assign in_ready = advance;

  // Split the flat input into rows.
  logic [WIDTH-1:0] row [NUM_ROWS];
  genvar k;
  generate
    for (k = 0; k < NUM_ROWS; k++) begin : g_split
      assign row[k] = in_rows[k*WIDTH +: WIDTH];
    end
  endgenerate

  // ---------------- Layer 1 ----------------
  logic [WIDTH-1:0] l1_sa, l1_ca, l1_sb, l1_cb;
  csa_layer #(.WIDTH(WIDTH)) u_l1a (
    .a(row[0]), .b(row[1]), .c(row[2]), .s(l1_sa), .cy(l1_ca));
  csa_layer #(.WIDTH(WIDTH)) u_l1b (
    .a(row[3]), .b(row[4]), .c(row[5]), .s(l1_sb), .cy(l1_cb));

  logic               st1_vld;
  logic [S1_BITS-1:0] st1_dat;
  csa_pipe_stage #(.WIDTH(WIDTH), .ROWS(S1_ROWS)) u_st1 (
    .clk(clk), .rst(rst), .en(advance), .vld_i(in_valid),
    .dat_i({row[7], row[6], l1_cb, l1_sb, l1_ca, l1_sa}),
    .vld_o(st1_vld), .dat_o(st1_dat));

  logic [WIDTH-1:0] q1 [S1_ROWS];
  generate
    for (k = 0; k < S1_ROWS; k++) begin : g_q1
      assign q1[k] = st1_dat[k*WIDTH +: WIDTH];
    end
  endgenerate

  // ---------------- Layer 2 ----------------
  // q1: 0=sum A, 1=carry A, 2=sum B, 3=carry B, 4=row6, 5=row7
  logic [WIDTH-1:0] l2_sa, l2_ca, l2_sb, l2_cb;
  csa_layer #(.WIDTH(WIDTH)) u_l2a (
    .a(q1[0]), .b(q1[1]), .c(q1[2]), .s(l2_sa), .cy(l2_ca));
  csa_layer #(.WIDTH(WIDTH)) u_l2b (
    .a(q1[4]), .b(q1[5]), .c(q1[3]), .s(l2_sb), .cy(l2_cb));

  logic               st2_vld;
  logic [S2_BITS-1:0] st2_dat;
  csa_pipe_stage #(.WIDTH(WIDTH), .ROWS(S2_ROWS)) u_st2 (
    .clk(clk), .rst(rst), .en(advance), .vld_i(st1_vld),
    .dat_i({l2_cb, l2_sb, l2_ca, l2_sa}),
    .vld_o(st2_vld), .dat_o(st2_dat));

  logic [WIDTH-1:0] q2 [S2_ROWS];
  generate
    for (k = 0; k < S2_ROWS; k++) begin : g_q2
      assign q2[k] = st2_dat[k*WIDTH +: WIDTH];
    end
  endgenerate

  // ---------------- Layers 3 and 4 ----------------
  logic [WIDTH-1:0] l3_s, l3_c, l4_s, l4_c;
  csa_layer #(.WIDTH(WIDTH)) u_l3 (
    .a(q2[0]), .b(q2[1]), .c(q2[2]), .s(l3_s), .cy(l3_c));
  csa_layer #(.WIDTH(WIDTH)) u_l4 (
    .a(l3_s), .b(l3_c), .c(q2[3]), .s(l4_s), .cy(l4_c));

  logic               st3_vld;
  logic [S3_BITS-1:0] st3_dat;
  csa_pipe_stage #(.WIDTH(WIDTH), .ROWS(S3_ROWS)) u_st3 (
    .clk(clk), .rst(rst), .en(advance), .vld_i(st2_vld),
    .dat_i({l4_c, l4_s}),
    .vld_o(st3_vld), .dat_o(st3_dat));

  // ---------------- Final addition ----------------
  logic [WIDTH-1:0] merged;
  csa_final_add #(.WIDTH(WIDTH)) u_add (
    .sum_row(st3_dat[0 +: WIDTH]),
    .carry_row(st3_dat[WIDTH +: WIDTH]),
    .total(merged));

  csa_pipe_stage #(.WIDTH(WIDTH), .ROWS(1)) u_st4 (
    .clk(clk), .rst(rst), .en(advance), .vld_i(st3_vld),
    .dat_i(merged),
    .vld_o(out_valid), .dat_o(out_sum));
endmodule

// File: rtl/csa_tree_pipe_chk.sv
module csa_tree_pipe_chk
  import csa_tree_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum
);
  localparam int unsigned OCC_W = $clog2(LATENCY + 1) + 1;

  logic             take, give;
  logic [OCC_W-1:0] occ;
  assign take = in_valid & in_ready;
  assign give = out_valid & out_ready;

  // Row sets currently inside the block.
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OCC_W'(take) - OCC_W'(give);
  end

  p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(LATENCY) && !out_ready) |-> !in_ready);

  p_bounded_fill_r4: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(LATENCY));

  p_no_phantom_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != '0));

  p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

bind csa_tree_pipe csa_tree_pipe_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

// File: tb/csa_tree_pipe_tb.sv
module csa_tree_pipe_tb;
  localparam int W = 32;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b1;
  logic [N*W-1:0] in_rows = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_sum;

  always #2.5 clk = ~clk;

  csa_tree_pipe #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_rows(in_rows), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum));

  int n_chk = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  int out_cnt = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  logic [W-1:0] expq [$];

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_sum(logic [N*W-1:0] r);
    logic [W-1:0] s = '0;
    for (int k = 0; k < N; k++) s = s + r[k*W +: W];
    return s;
  endfunction

  function automatic logic [N*W-1:0] fill(logic [W-1:0] v);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = v;
    return r;
  endfunction

  // Mid-cycle sampler: record accepted inputs, compare delivered results (R1).
  always @(negedge clk) begin
    logic [W-1:0] e;
    #1;
    if (!rst) begin
      if (in_valid && in_ready) begin
        expq.push_back(ref_sum(in_rows));
        acc_cnt++;
      end
      if (out_valid && out_ready) begin
        out_cnt++;
        if (expq.size() == 0) chk(1'b0, {cur_tag, "/R1 unexpected result"}, out_sum, '0);
        else begin
          e = expq.pop_front();
          chk(out_sum == e, {cur_tag, "/R1 sum"}, out_sum, e);
        end
      end
    end
  end

  task automatic drive(logic [N*W-1:0] r);
    @(negedge clk);
    in_rows  = r;
    in_valid = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain_check(string tag);
    idle(8);
    #2;
    chk(expq.size() == 0, {tag, " drained"}, W'(expq.size()), '0);
  endtask

  task automatic t_reset_state;
    cur_tag = "R7";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R7 out_valid after reset", W'(out_valid), '0);
    chk(in_ready == 1'b1, "R7 in_ready after reset", W'(in_ready), 1);
  endtask

  task automatic t_latency;
    cur_tag = "R3";
    drive(fill(32'h0000_0011));
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk(out_valid == (i == 4), "R3 latency", W'(out_valid), W'(i == 4));
    end
    drain_check("R3");
  endtask

  task automatic t_patterns;
    logic [N*W-1:0] r;
    cur_tag = "R1";
    drive('0);
    for (int k = 0; k < N; k++) r[k*W +: W] = W'(1) << (k * 4);
    drive(r);
    drive(fill(32'hAAAA_AAAA));
    drive(fill(32'h5555_5555));
    for (int k = 0; k < N; k++) r[k*W +: W] = (k % 2 == 0) ? 32'hAAAA_AAAA : 32'h5555_5555;
    drive(r);
    for (int k = 0; k < N; k++) r[k*W +: W] = 32'h1234_5678 * (k + 3) + k;
    drive(r);
    drain_check("R1");
  endtask

  task automatic t_wrap;
    cur_tag = "R2";
    drive(fill(32'hFFFF_FFFF));
    drive(fill(32'h8000_0000));
    idle(1);
    @(negedge clk);
    #2;
    chk(expq.size() == 2 && expq[0] == 32'hFFFF_FFF8 && expq[1] == 32'h0,
        "R2 expected wrap values queued", expq.size() > 0 ? expq[0] : '0, 32'hFFFF_FFF8);
    drain_check("R2");
  endtask

  task automatic t_back_to_back;
    int start_out;
    cur_tag = "R4";
    start_out = out_cnt;
    for (int j = 0; j < 20; j++) begin
      logic [N*W-1:0] r;
      for (int k = 0; k < N; k++) r[k*W +: W] = 32'h0F0F_1357 * (j + 1) ^ (32'h9E37_79B9 * k);
      drive(r);
      #2;
      chk(in_ready == 1'b1, "R4 accept every cycle", W'(in_ready), 1);
    end
    drain_check("R4");
    chk(out_cnt - start_out == 20, "R4 result count", W'(out_cnt - start_out), 20);
  endtask

  task automatic t_stall;
    int start_acc;
    logic [W-1:0] held;
    cur_tag = "R5";
    start_acc = acc_cnt;
    @(negedge clk);
    out_ready = 1'b0;
    for (int j = 0; j < 8; j++) drive(fill(W'(j * 7 + 1)));
    idle(1);
    #2;
    chk(acc_cnt - start_acc == 4, "R5 accepted under stall", W'(acc_cnt - start_acc), 4);
    chk(in_ready == 1'b0, "R5 in_ready low when stalled", W'(in_ready), 0);
    held = out_sum;
    idle(3);
    #2;
    chk(out_valid == 1'b1 && out_sum == held, "R5 output held", out_sum, held);
    @(negedge clk);
    out_ready = 1'b1;
    #2;
    chk(in_ready == 1'b1, "R5 in_ready with out_ready", W'(in_ready), 1);
    drain_check("R5");
  endtask

  task automatic t_idle_ignored;
    cur_tag = "R6";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_rows  = fill(W'(i * 32'h0101_0101 + 5));
      #2;
      chk(out_valid == 1'b0, "R6 no output without in_valid", W'(out_valid), 0);
    end
  endtask

  task automatic t_reset_flush;
    cur_tag = "R7";
    drive(fill(32'h0000_0003));
    drive(fill(32'h0000_0004));
    drive(fill(32'h0000_0005));
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expq.delete();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R7 in-flight data flushed", W'(out_valid), 0);
    end
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_patterns();
    t_wrap();
    t_back_to_back();
    t_stall();
    t_idle_ignored();
    t_reset_flush();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule